// File: doc/BRIEF.md
# Receiver Ready-to-Send Flow Control

This block drives one multipurpose output pin as an active-low ready-to-send line for a serial receiver. The line goes to the clear-to-send input of the partner transmitter, so a high level asks the partner to pause. The receiver deserializer and its three-character FIFO are outside the block. They appear only as a FIFO-full flag, a one-cycle start-bit pulse and a one-cycle character-read pulse.

A small state machine tracks the flow-control condition. It has three states:

- `S_IDLE`: flow control is off.
- `S_READY`: flow control is on and the receiver accepts data.
- `S_HALTED`: the FIFO is full and a fourth character has begun.

The transitions are as follows:

- `S_IDLE` goes to `S_READY` on the first clock with the enable set.
- `S_READY` goes to `S_HALTED` when a start bit arrives while the FIFO is full.
- `S_HALTED` goes to `S_READY` on a read pulse, or when the full flag is clear.
- Any state goes to `S_IDLE` when the enable is clear.

The pin level is the NAND of the shared port-register bit and an internal ready term. The ready term is high unless flow control is on and the machine is halted. The block never changes the register bit. Software must program that bit to 1 (the value that, on its own, drives the pin low) for the pin to show ready-to-send. With flow control off, the pin is the plain inverse of the register bit.

Top module: `rts_flow_ctrl`

## Requirements
- R1: While `rst_n` is low, the state is `S_IDLE` and `rts_pin` equals the inverse of `port_bit`.
- R2: With `fc_en` = 0, `rts_pin` equals the inverse of `port_bit` in the same cycle. `fifo_full`, `start_det` and `char_read` have no effect on the pin.
- R3: With `fc_en` = 1 and `port_bit` = 1, the machine enters `S_READY` one clock after leaving `S_IDLE`, and `rts_pin` is 0.
- R4: In `S_READY`, a cycle with both `fifo_full` = 1 and `start_det` = 1 moves the machine to `S_HALTED` on the next clock. The pin is then 1.
- R5: In `S_READY`, `start_det` while `fifo_full` = 0 leaves the machine in `S_READY`, and the pin stays 0 when `port_bit` = 1.
- R6: In `S_HALTED`, a cycle with `char_read` = 1 or `fifo_full` = 0 returns the machine to `S_READY` on the next clock.
- R7: With `port_bit` = 0, `rts_pin` is 1 in every state.
- R8: Clearing `fc_en` returns `rts_pin` to the inverse of `port_bit` in the same cycle. The machine is in `S_IDLE` on the next clock.
- R9: In `S_HALTED`, while `fifo_full` = 1 and `char_read` = 0, the machine stays halted, including when further start pulses arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_en | input | 1 | Mode bit that hands the pin to the receiver for flow control |
| fifo_full | input | 1 | Receiver FIFO holds three characters |
| start_det | input | 1 | One-cycle pulse: the receiver detected a start bit |
| char_read | input | 1 | One-cycle pulse: a character was read from the FIFO |
| port_bit | input | 1 | Shared output-port register bit for this pin |
| rts_pin | output | 1 | Pin level: active-low ready-to-send |

## Verification
The block has no parameters, so the bench builds the single default configuration. In that configuration every state and every transition is reachable. The directed sequence includes these corner cases:

- a start pulse that arrives while the FIFO is not full;
- repeated start pulses while the machine is halted;
- resuming through a read pulse while the full flag is still set;
- resuming through the full flag dropping;
- disabling flow control from the halted state.

A long pseudo-random run then mixes all five inputs. It compares the pin on every clock against a behavioural model kept as an integer state.

// File: rtl/rts_fc_pkg.sv
package rts_fc_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'b00,
        S_READY  = 2'b01,
        S_HALTED = 2'b10
    } rts_state_t;
endpackage

// File: rtl/rts_fc_fsm.sv
module rts_fc_fsm
    import rts_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fc_en,
    input  logic       fifo_full,
    input  logic       start_det,
    input  logic       char_read,
    output rts_state_t state
);
    rts_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        if (!fc_en) begin
            state_d = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:   state_d = S_READY;
                S_READY:  if (fifo_full && start_det) state_d = S_HALTED;
                S_HALTED: if (char_read || !fifo_full) state_d = S_READY;
                default:  state_d = S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rts_fc_pin.sv
module rts_fc_pin
    import rts_fc_pkg::*;
(
    input  logic       fc_en,
    input  rts_state_t state,
    input  logic       port_bit,
    output logic       rts_pin
);
    logic ready_term;

    // Output logic: ready term, then NAND with the register bit
    always_comb begin
        ready_term = 1'b1;
        unique case (state)
            S_IDLE:   ready_term = 1'b1;
            S_READY:  ready_term = 1'b1;
            S_HALTED: ready_term = !fc_en;
            default:  ready_term = 1'b1;
        endcase
        rts_pin = !(port_bit && ready_term);
    end
endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
    import rts_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fc_en,
    input  logic fifo_full,
    input  logic start_det,
    input  logic char_read,
    input  logic port_bit,
    output logic rts_pin
);
    rts_state_t state_q;

    rts_fc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fc_en     (fc_en),
        .fifo_full (fifo_full),
        .start_det (start_det),
        .char_read (char_read),
        .state     (state_q)
    );

    rts_fc_pin u_pin (
        .fc_en    (fc_en),
        .state    (state_q),
        .port_bit (port_bit),
        .rts_pin  (rts_pin)
    );
endmodule

// File: rtl/rts_fc_chk.sv
module rts_fc_chk
    import rts_fc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       fc_en,
    input logic       fifo_full,
    input logic       start_det,
    input logic       char_read,
    input logic       port_bit,
    input logic       rts_pin,
    input rts_state_t state_q
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> state_q == S_IDLE);

    p_disabled_follows_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |-> rts_pin == !port_bit);

    p_enter_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && state_q == S_IDLE) |=> (!fc_en || state_q == S_READY));

    p_halt_on_fourth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && state_q == S_READY && fifo_full && start_det) |=> (!fc_en || state_q == S_HALTED));

    p_no_halt_unless_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READY && !fifo_full) |=> state_q != S_HALTED);

    p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALTED && (char_read || !fifo_full)) |=> state_q != S_HALTED);

    p_reg_low_pin_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_bit |-> rts_pin);

    p_disable_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> state_q == S_IDLE);

    p_hold_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && state_q == S_HALTED && fifo_full && !char_read) |=> (!fc_en || state_q == S_HALTED));
endmodule

bind rts_flow_ctrl rts_fc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fc_en     (fc_en),
    .fifo_full (fifo_full),
    .start_det (start_det),
    .char_read (char_read),
    .port_bit  (port_bit),
    .rts_pin   (rts_pin),
    .state_q   (state_q)
);

// File: tb/tb_rts_flow_ctrl.sv
`timescale 1ns/1ps
module tb_rts_flow_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fc_en = 1'b0, fifo_full = 1'b0, start_det = 1'b0, char_read = 1'b0, port_bit = 1'b0;
    logic rts_pin;

    int checks = 0;
    int errors = 0;
    int mst = 0;     // model state: 0 idle, 1 ready, 2 halted
    bit done = 1'b0;

    always #4 clk = ~clk;

    rts_flow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .fifo_full(fifo_full),
        .start_det(start_det), .char_read(char_read), .port_bit(port_bit),
        .rts_pin(rts_pin)
    );

    function automatic logic exp_pin();
        return !(port_bit && !(fc_en && mst == 2));
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: rts_pin=%0b expected %0b", tag, $time, act, exp);
        end
    endtask

    // Apply inputs, compare pin, then advance the model at the clock edge
    task automatic cyc(string tag, logic f, logic full, logic st, logic rd, logic pb);
        fc_en = f; fifo_full = full; start_det = st; char_read = rd; port_bit = pb;
        #1;
        check(tag, rts_pin, exp_pin());
        @(posedge clk);
        if (!rst_n || !fc_en) mst = 0;
        else if (mst == 0) mst = 1;
        else if (mst == 1 && fifo_full && start_det) mst = 2;
        else if (mst == 2 && (char_read || !fifo_full)) mst = 1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        // R1: reset state
        cyc("R1", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc("R1", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        cyc("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;
        // R2: disabled, pin follows register, flags ignored
        cyc("R2", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc("R2", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        cyc("R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        // R3: enable, ready
        cyc("R3", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc("R3", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        // R5: start without full
        cyc("R5", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        cyc("R5", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        // R4: full and fourth start bit
        cyc("R4", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        // R9: stay halted
        cyc("R9", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc("R9", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        // R7: register low forces pin high while halted
        cyc("R7", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // R6: resume by read while full still set
        cyc("R6", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        cyc("R6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        // R7: register low while ready
        cyc("R7", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R4 then R6 via full dropping
        cyc("R4", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        cyc("R6", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc("R6", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        // R8: disable from halted
        cyc("R8", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc("R8", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        cyc("R8", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R8", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc("R8", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        // Mixed stimulus against the model
        for (int i = 0; i < 2000; i++) begin
            logic [4:0] r;
            r = 5'($urandom);
            cyc("random", (i % 97) > 10 ? 1'b1 : r[0], r[1] | r[2], r[3], r[4] & r[1],
                (i % 53) > 5 ? 1'b1 : r[2]);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end
endmodule